// File: doc/BRIEF.md
# Banked-Register I2C Target

This block lets an external I2C host reach a chip-internal register file. It watches the SCL and SDA lines through short synchronizers on the system clock. It recognises START and STOP conditions and answers one of two 7-bit device addresses; a static strap input picks which one. It answers by pulling SDA low through an open-drain enable. The register file itself lives outside the block. The block drives a one-cycle write strobe with address and data, and it presents a read address whose data comes back combinationally.

A write transaction has three parts: the address byte with R/W at 0, a two-byte register pointer sent high byte first, then any number of 16-bit words, each sent high byte first. Every word is committed once both of its bytes have arrived, and the pointer then steps by one. A read transaction has no pointer phase. It starts at whatever pointer the last write left behind and streams 16-bit words until the host declines a byte. The pointer survives STOP conditions, so a pointer-only write followed by a read is the normal way to fetch a register.

Top module: `regbus_i2c_target`

## Requirements
- R1: After reset, `sda_pull_low` and `wr_en` are 0 and `rd_addr` is 0.
- R2: The block acknowledges an address byte whose upper seven bits are 7'h48 when `addr_sel` is 0, or 7'h5D when `addr_sel` is 1. An acknowledge means `sda_pull_low` is 1 while SCL is high during the ninth clock.
- R3: For any other address the block never asserts `sda_pull_low` and performs no write until the next START.
- R4: In a write (R/W bit, the byte LSB, equal to 0), bits travel MSB first. The block acknowledges every byte. After the second data byte it pulses `wr_en` for exactly one cycle, with `wr_addr` equal to the pointer and `wr_data` equal to {first data byte, second data byte}.
- R5: After each committed word the pointer increments by one, so consecutive words in one transaction land at consecutive addresses.
- R6: A word whose second byte never arrives, because a STOP comes first, causes no write.
- R7: In a read (R/W bit 1), the block fetches the word at the pointer, sends its high byte then its low byte MSB first, and advances the pointer by one per fetched word. `rd_addr` always shows the pointer.
- R8: A host acknowledge after a byte continues the read. A host NACK makes the block release SDA and drive nothing more until the next START.
- R9: The pointer is kept across STOP conditions and separate transactions.
- R10: A START received mid-transaction, a repeated START, restarts byte framing at the address byte.
- R11: A STOP releases SDA and ends the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_sel | input | 1 | Strap choosing device address 7'h48 (0) or 7'h5D (1) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 16 | Register address for the write |
| wr_data | output | 16 | Register data for the write |
| rd_addr | output | 16 | Current register pointer, used as read address |
| rd_data | input | 16 | Register contents at `rd_addr` |

## Verification
The hardest situation to reach from the ports is the seam between a write that only loads the pointer and a later read that must pick up exactly there, especially after an earlier read has already advanced the pointer. The stimulus gets there with pointer-only writes and then back-to-back reads that end on a host NACK. A repeated START is injected mid-pointer to prove framing restarts. Random word bursts at random pointers with a random address strap are written and then read back, and a half-delivered word is cut off by STOP.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    localparam int PTR_W  = 16;
    localparam int WORD_W = 16;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SEND,
        ST_MACK
    } st_e;

    typedef enum logic [2:0] {
        K_ADDR,
        K_PTRH,
        K_PTRL,
        K_DH,
        K_DL
    } kind_e;

    typedef struct packed {
        st_e               st;
        kind_e             kind;
        logic [CNT_W-1:0]  bit_cnt;
        logic [7:0]        rx_sh;
        logic [7:0]        tx_sh;
        logic [7:0]        tx_lo;
        logic [7:0]        hold;
        logic [PTR_W-1:0]  ptr;
        logic              rd_mode;
        logic              mack;
        logic              oe;
        logic              wr_en;
        logic [PTR_W-1:0]  wr_addr;
        logic [WORD_W-1:0] wr_data;
    } fsm_t;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o  = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
    import i2ct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [6:0]        own_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [PTR_W-1:0]  rd_addr
);
    localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

    fsm_t d, q;
    logic start_evt, stop_evt;

    assign start_evt = scl & sda_fall;
    assign stop_evt  = scl & sda_rise;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (start_evt) begin
            d.st      = ST_RECV;
            d.kind    = K_ADDR;
            d.bit_cnt = '0;
            d.oe      = 1'b0;
        end else if (stop_evt) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_RECV: begin
                    if (scl_rise && q.bit_cnt < BYTE_BITS) begin
                        d.rx_sh   = {q.rx_sh[6:0], sda};
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end else if (scl_fall && q.bit_cnt == BYTE_BITS) begin
                        d.oe = 1'b1;
                        d.st = ST_ACK;
                        unique case (q.kind)
                            K_ADDR: begin
                                if (q.rx_sh[7:1] == own_addr) begin
                                    d.rd_mode = q.rx_sh[0];
                                    d.kind    = K_PTRH;
                                end else begin
                                    d.oe = 1'b0;
                                    d.st = ST_IDLE;
                                end
                            end
                            K_PTRH: begin
                                d.ptr[15:8] = q.rx_sh;
                                d.kind      = K_PTRL;
                            end
                            K_PTRL: begin
                                d.ptr[7:0] = q.rx_sh;
                                d.kind     = K_DH;
                            end
                            K_DH: begin
                                d.hold = q.rx_sh;
                                d.kind = K_DL;
                            end
                            default: begin
                                d.wr_en   = 1'b1;
                                d.wr_addr = q.ptr;
                                d.wr_data = {q.hold, q.rx_sh};
                                d.ptr     = q.ptr + 16'd1;
                                d.kind    = K_DH;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.bit_cnt = '0;
                        if (q.rd_mode) begin
                            d.tx_sh = rd_data[15:8];
                            d.tx_lo = rd_data[7:0];
                            d.ptr   = q.ptr + 16'd1;
                            d.oe    = ~rd_data[15];
                            d.kind  = K_DH;
                            d.st    = ST_SEND;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_RECV;
                        end
                    end
                end
                ST_SEND: begin
                    if (scl_fall) begin
                        if (q.bit_cnt == BYTE_BITS - 1'b1) begin
                            d.oe = 1'b0;
                            d.st = ST_MACK;
                        end else begin
                            d.bit_cnt = q.bit_cnt + 1'b1;
                            d.tx_sh   = {q.tx_sh[6:0], 1'b0};
                            d.oe      = ~q.tx_sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.bit_cnt = '0;
                            d.st      = ST_SEND;
                            if (q.kind == K_DH) begin
                                d.kind  = K_DL;
                                d.tx_sh = q.tx_lo;
                                d.oe    = ~q.tx_lo[7];
                            end else begin
                                d.kind  = K_DH;
                                d.tx_sh = rd_data[15:8];
                                d.tx_lo = rd_data[7:0];
                                d.ptr   = q.ptr + 16'd1;
                                d.oe    = ~rd_data[15];
                            end
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= K_ADDR;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign rd_addr = q.ptr;

    // R4
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |=> !q.wr_en);
    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> (q.ptr == q.wr_addr + 16'd1));
    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !q.oe);
    // R10
    start_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (q.st == ST_RECV && q.kind == K_ADDR && q.bit_cnt == '0));
    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe);
    // R4
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.bit_cnt <= BYTE_BITS);
endmodule

// File: rtl/regbus_i2c_target.sv
module regbus_i2c_target
    import i2ct_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR_LO = 7'h48,
    parameter logic [6:0] DEV_ADDR_HI = 7'h5D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    input  logic              addr_sel,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [PTR_W-1:0]  rd_addr,
    input  logic [WORD_W-1:0] rd_data
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw, line_lvl, line_rise, line_fall;
    logic [6:0]         own_addr;

    assign line_raw = {sda_in, scl_in};
    assign own_addr = addr_sel ? DEV_ADDR_HI : DEV_ADDR_LO;

    for (genvar i = 0; i < N_LINES; i++) begin : g_sync
        i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (line_raw[i]),
            .level_o (line_lvl[i]),
            .rise_o  (line_rise[i]),
            .fall_o  (line_fall[i])
        );
    end

    i2ct_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (line_lvl[0]),
        .scl_rise (line_rise[0]),
        .scl_fall (line_fall[0]),
        .sda      (line_lvl[1]),
        .sda_rise (line_rise[1]),
        .sda_fall (line_fall[1]),
        .own_addr (own_addr),
        .rd_data  (rd_data),
        .sda_oe   (sda_pull_low),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr)
    );
endmodule

// File: tb/tb_regbus_i2c_target.sv
module tb_regbus_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        strap = 1'b0;
    logic        bus_sda;
    logic        sda_pull_low;
    logic        wr_en;
    logic [15:0] wr_addr, wr_data, rd_addr, rd_data;

    logic [15:0] regs [0:63];
    logic [15:0] exp_regs [0:63];
    logic [15:0] wbuf [0:7];
    logic [15:0] rbuf [0:7];
    int wr_count = 0;
    int pull_cnt = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    assign bus_sda = m_sda & ~sda_pull_low;
    assign rd_data = regs[rd_addr[5:0]];

    regbus_i2c_target dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(bus_sda),
        .sda_pull_low(sda_pull_low), .addr_sel(strap),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) regs[i] <= 16'h0;
            wr_count <= 0;
            pull_cnt <= 0;
        end else begin
            if (wr_en) begin
                regs[wr_addr[5:0]] <= wr_data;
                wr_count <= wr_count + 1;
            end
            if (sda_pull_low) pull_cnt <= pull_cnt + 1;
        end
    end

    function automatic logic [6:0] own_addr(input logic sel);
        return sel ? 7'h5D : 7'h48;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = bus_sda;  tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    // full write: address, pointer, n words from wbuf; returns number of missing ACKs
    task automatic do_write(input logic [6:0] a7, input logic [15:0] ptr, input int n, output int nacks);
        logic ack;
        nacks = 0;
        i2c_start();
        write_byte({a7, 1'b0}, ack); if (!ack) nacks++;
        write_byte(ptr[15:8], ack);  if (!ack) nacks++;
        write_byte(ptr[7:0], ack);   if (!ack) nacks++;
        for (int i = 0; i < n; i++) begin
            write_byte(wbuf[i][15:8], ack); if (!ack) nacks++;
            write_byte(wbuf[i][7:0], ack);  if (!ack) nacks++;
        end
        i2c_stop();
    endtask

    task automatic do_read(input logic [6:0] a7, input int n, output int nacks, output logic rel_ok);
        logic ack;
        logic [7:0] hi, lo;
        nacks = 0;
        i2c_start();
        write_byte({a7, 1'b1}, ack); if (!ack) nacks++;
        for (int i = 0; i < n; i++) begin
            read_byte(hi, 1'b1);
            read_byte(lo, i < n - 1);
            rbuf[i] = {hi, lo};
        end
        tick(Q);
        rel_ok = ~sda_pull_low;
        i2c_stop();
    endtask

    task automatic model_write(input logic [15:0] ptr, input int n);
        for (int i = 0; i < n; i++) exp_regs[(ptr + i) & 16'h3F] = wbuf[i];
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int nk, wc0, pc0;
        logic rel;
        logic [15:0] p;
        int n;
        int unsigned seed_v;
        seed_v = $urandom(32'd5150);
        for (int i = 0; i < 64; i++) exp_regs[i] = 16'h0;
        tick(10);
        // R1 reset state
        check("R1 sda_pull_low", {31'd0, sda_pull_low}, 32'd0);
        check("R1 wr_en", {31'd0, wr_en}, 32'd0);
        check("R1 rd_addr", {16'd0, rd_addr}, 32'd0);
        rst_n = 1'b1;
        tick(10);

        // R2 R4 R5 four words at pointer 5 with strap 0
        strap = 1'b0;
        wbuf[0] = 16'hA1B2; wbuf[1] = 16'h0380; wbuf[2] = 16'hFFFF; wbuf[3] = 16'h5A00;
        wc0 = wr_count;
        do_write(own_addr(1'b0), 16'd5, 4, nk);
        model_write(16'd5, 4);
        check("R2 R4 acks strap0", nk, 0);
        check("R4 write count", wr_count - wc0, 4);
        for (int i = 5; i < 9; i++) check("R5 word at ptr", {16'd0, regs[i]}, {16'd0, exp_regs[i]});

        // R2 strap 1
        strap = 1'b1;
        wbuf[0] = 16'h1234;
        do_write(own_addr(1'b1), 16'd10, 1, nk);
        model_write(16'd10, 1);
        check("R2 acks strap1", nk, 0);
        check("R4 word strap1", {16'd0, regs[10]}, {16'd0, exp_regs[10]});

        // R3 other address ignored
        wc0 = wr_count; pc0 = pull_cnt;
        wbuf[0] = 16'hDEAD;
        do_write(own_addr(1'b0), 16'd11, 1, nk);
        check("R3 no ack", nk, 5);
        check("R3 never drove", pull_cnt - pc0, 0);
        check("R3 no write", wr_count - wc0, 0);

        // R6 half word then STOP
        begin
            logic ack;
            wc0 = wr_count;
            i2c_start();
            write_byte({own_addr(1'b1), 1'b0}, ack);
            write_byte(8'h00, ack);
            write_byte(8'd20, ack);
            write_byte(8'h77, ack);
            i2c_stop();
            check("R6 no write", wr_count - wc0, 0);
            check("R6 reg untouched", {16'd0, regs[20]}, 32'd0);
        end

        // R7 R8 pointer-only write then read
        do_write(own_addr(1'b1), 16'd5, 0, nk);
        check("R11 released after stop", {31'd0, sda_pull_low}, 32'd0);
        do_read(own_addr(1'b1), 2, nk, rel);
        check("R7 read ack", nk, 0);
        check("R7 word0", {16'd0, rbuf[0]}, {16'd0, exp_regs[5]});
        check("R7 word1", {16'd0, rbuf[1]}, {16'd0, exp_regs[6]});
        check("R8 released after nack", {31'd0, rel}, 32'd1);
        // R9 continue from retained pointer
        do_read(own_addr(1'b1), 2, nk, rel);
        check("R9 word2", {16'd0, rbuf[0]}, {16'd0, exp_regs[7]});
        check("R9 word3", {16'd0, rbuf[1]}, {16'd0, exp_regs[8]});
        check("R7 pointer after reads", {16'd0, rd_addr}, 32'd9);

        // R10 repeated start mid-pointer
        begin
            logic ack;
            wc0 = wr_count;
            i2c_start();
            write_byte({own_addr(1'b1), 1'b0}, ack);
            write_byte(8'h00, ack);
            wbuf[0] = 16'hC0DE;
            do_write(own_addr(1'b1), 16'd30, 1, nk);
            model_write(16'd30, 1);
            check("R10 acks after restart", nk, 0);
            check("R10 single write", wr_count - wc0, 1);
            check("R10 word", {16'd0, regs[30]}, {16'd0, exp_regs[30]});
        end

        // random bursts
        for (int it = 0; it < 12; it++) begin
            strap = 1'($urandom());
            p = 16'($urandom() % 56);
            n = 1 + int'($urandom() % 3);
            for (int i = 0; i < n; i++) wbuf[i] = 16'($urandom());
            do_write(own_addr(strap), p, n, nk);
            model_write(p, n);
            check("R4 random acks", nk, 0);
            do_write(own_addr(strap), p, 0, nk);
            do_read(own_addr(strap), n, nk, rel);
            for (int i = 0; i < n; i++)
                check("R7 random readback", {16'd0, rbuf[i]}, {16'd0, exp_regs[(p + i) & 16'h3F]});
            check("R8 random release", {31'd0, rel}, 32'd1);
        end

        done = 1'b1;
        finish_run();
    end
endmodule